// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port memory array and watches the access requests of its left and right ports. Each port has an active-low select and an address. When both ports are selected at once and point at the same location, the arbiter decides which port owns that location. It then holds the other port off with that port's active-low busy flag, which idles high. Collisions on different locations cannot happen, so two accesses to different addresses proceed untouched.

Ownership goes to the port whose access began earlier, counted in whole clocks. An access begins at the first clock edge on which the port's select is sampled low after being sampled high, or after reset. If both ports begin on the same edge, the left port wins. While the losing port is held off, its write strobe toward the array is suppressed, so the winner's data stays intact. When the winner deselects, or either port moves to another address, the collision ends. On the next edge the loser's busy flag rises and its pending access goes ahead.

Top module: `dp_collide_arb`

## Requirements
- R1: While reset is asserted (rst_n low), both busy outputs are high, without waiting for a clock edge. All ownership and access-age state is cleared.
- R2: A busy output goes low only after a clock edge that sampled a collision: both selects low and both addresses equal. This applies to every address value, from 0 through all ones. Different addresses, or only one port selected, leave both busy outputs high.
- R3: When one port's access began on an earlier edge than the other's, the later port is the loser. Its busy goes low from the first edge that samples the collision, and the earlier port's busy stays high.
- R4: The loser's busy stays low for as long as the collision persists. After the winner raises its select, the loser's busy returns high on the next clock edge.
- R5: When both ports begin colliding accesses on the same edge, the left port wins and only the right busy goes low.
- R6: A port's gated write strobe is low only when that port's select is low, its raw write strobe is low, and it is not the loser of a collision present in the same cycle. The blocking takes effect combinationally, in the cycle the collision first appears.
- R7: If either port changes its address so that the addresses no longer match, the loser's busy returns high on the next clock edge.
- R8: The two busy outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left port select, active low |
| l_addr | input | ADDR_W (10) | Left port address |
| l_we_n | input | 1 | Left raw write strobe, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_addr | input | ADDR_W (10) | Right port address |
| r_we_n | input | 1 | Right raw write strobe, active low |
| l_busy_n | output | 1 | Left busy, active low: the left port must wait |
| r_busy_n | output | 1 | Right busy, active low: the right port must wait |
| l_we_gated_n | output | 1 | Left write strobe toward the array after blocking |
| r_we_gated_n | output | 1 | Right write strobe toward the array after blocking |

## Verification
The properties assume that selects, addresses and write strobes change only between clock edges, so that each edge samples a settled request. The stimulus changes every input on the falling edge. It samples registered flags just after the rising edge and the combinational write strobes just after the falling edge. The properties also assume that each edge sees one coherent request per port. The bench never toggles a select twice within a clock. Between scenarios it returns both ports to idle for a cycle, so every access start is unambiguous.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpc_port_track.sv
// Tracks whether a port's access is in progress and flags the edge it starts on.
module dpc_port_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic active_q,
  output logic start
);
  logic active_d;

  always_comb begin
    active_d = ~sel_n;
    start    = ~sel_n & ~active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end
endmodule

// File: rtl/dpc_owner_fsm.sv
// Keeps access age order and ownership of a contended location.
module dpc_owner_fsm
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   collide,
  input  logic   l_start,
  input  logic   r_start,
  input  logic   l_active,
  input  logic   r_active,
  output owner_e own_q,
  output owner_e own_d
);
  logic left_elder_q, left_elder_d;

  // Age order: the earlier starter is elder; a same-edge start favours left.
  always_comb begin
    left_elder_d = left_elder_q;
    if (l_start && r_start)  left_elder_d = 1'b1;
    else if (l_start)        left_elder_d = ~r_active;
    else if (r_start)        left_elder_d = l_active;
  end

  always_comb begin
    if (!collide)               own_d = OWN_NONE;
    else if (own_q != OWN_NONE) own_d = own_q;
    else                        own_d = left_elder_d ? OWN_LEFT : OWN_RIGHT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_elder_q <= 1'b1;
      own_q        <= OWN_NONE;
    end else begin
      left_elder_q <= left_elder_d;
      own_q        <= own_d;
    end
  end
endmodule

// File: rtl/dpc_we_gate.sv
// Suppresses a port's write strobe while it loses a collision.
module dpc_we_gate (
  input  logic sel_n,
  input  logic we_n,
  input  logic lose,
  output logic we_gated_n
);
  always_comb we_gated_n = we_n | sel_n | lose;
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we_n,
  input  logic              r_sel_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_we_gated_n,
  output logic              r_we_gated_n
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] sel_n_v, active_v, start_v, we_n_v, lose_v, gated_v;
  logic             collide;
  owner_e           own_q, own_d;

  assign sel_n_v = {r_sel_n, l_sel_n};
  assign we_n_v  = {r_we_n, l_we_n};
  assign collide = ~l_sel_n & ~r_sel_n & (l_addr == r_addr);

  // Port 0 is left, port 1 is right.
  assign lose_v = {own_d == OWN_LEFT, own_d == OWN_RIGHT};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpc_port_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n    (sel_n_v[p]),
      .active_q (active_v[p]),
      .start    (start_v[p])
    );
    dpc_we_gate u_gate (
      .sel_n      (sel_n_v[p]),
      .we_n       (we_n_v[p]),
      .lose       (lose_v[p]),
      .we_gated_n (gated_v[p])
    );
  end

  dpc_owner_fsm u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .collide  (collide),
    .l_start  (start_v[0]),
    .r_start  (start_v[1]),
    .l_active (active_v[0]),
    .r_active (active_v[1]),
    .own_q    (own_q),
    .own_d    (own_d)
  );

  assign l_busy_n     = (own_q != OWN_RIGHT);
  assign r_busy_n     = (own_q != OWN_LEFT);
  assign l_we_gated_n = gated_v[0];
  assign r_we_gated_n = gated_v[1];
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_sel_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_we_n,
  input logic              r_sel_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_we_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_we_gated_n,
  input logic              r_we_gated_n
);
  logic hit;
  assign hit = !l_sel_n && !r_sel_n && (l_addr == r_addr);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (l_busy_n && r_busy_n);
    end
  end

  assert_busy_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hit) |-> (l_busy_n && r_busy_n));

  assert_loser_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && hit) |=> !r_busy_n);

  assert_tie_left_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(l_sel_n) && $past(r_sel_n)) |=> (!r_busy_n && l_busy_n));

  assert_left_strobe_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && hit) |-> l_we_gated_n);

  assert_right_strobe_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && hit) |-> r_we_gated_n);

  assert_busy_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_n || r_busy_n));
endmodule

bind dp_collide_arb dpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel_n(l_sel_n), .l_addr(l_addr), .l_we_n(l_we_n),
  .r_sel_n(r_sel_n), .r_addr(r_addr), .r_we_n(r_we_n),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_we_gated_n(l_we_gated_n), .r_we_gated_n(r_we_gated_n)
);

// File: tb/tb_dp_collide_arb.sv
module tb_dp_collide_arb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          l_sel_n, l_we_n, r_sel_n, r_we_n;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy_n, r_busy_n, l_we_gated_n, r_we_gated_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dp_collide_arb #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_addr(l_addr), .l_we_n(l_we_n),
    .r_sel_n(r_sel_n), .r_addr(r_addr), .r_we_n(r_we_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_we_gated_n(l_we_gated_n), .r_we_gated_n(r_we_gated_n)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Drive both ports on the falling edge, then settle combinational outputs.
  task automatic drive(input logic ls, input logic [AW-1:0] la, input logic lw,
                       input logic rs, input logic [AW-1:0] ra, input logic rw);
    @(negedge clk);
    l_sel_n = ls; l_addr = la; l_we_n = lw;
    r_sel_n = rs; r_addr = ra; r_we_n = rw;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    drive(1'b1, '0, 1'b1, 1'b1, '0, 1'b1);
    tick();
  endtask

  task automatic t_reset();
    check("R1 left busy after reset", l_busy_n, 1'b1);
    check("R1 right busy after reset", r_busy_n, 1'b1);
  endtask

  task automatic t_no_collision();
    drive(1'b0, 10'd0, 1'b0, 1'b0, 10'h3FF, 1'b0);
    check("R2 left strobe passes, distinct addr", l_we_gated_n, 1'b0);
    check("R2 right strobe passes, distinct addr", r_we_gated_n, 1'b0);
    tick();
    check("R2 left busy, distinct addr", l_busy_n, 1'b1);
    check("R2 right busy, distinct addr", r_busy_n, 1'b1);
    idle();
    drive(1'b0, 10'h155, 1'b1, 1'b1, 10'h155, 1'b1);
    tick();
    check("R2 single port, same addr: left", l_busy_n, 1'b1);
    check("R2 single port, same addr: right", r_busy_n, 1'b1);
    idle();
  endtask

  task automatic t_left_first();
    drive(1'b0, 10'h2AA, 1'b0, 1'b1, 10'h0, 1'b1);
    tick();
    check("R3 left alone, no busy", r_busy_n, 1'b1);
    drive(1'b0, 10'h2AA, 1'b0, 1'b0, 10'h2AA, 1'b0);
    check("R6 right strobe blocked at collision", r_we_gated_n, 1'b1);
    check("R6 left strobe passes as winner", l_we_gated_n, 1'b0);
    tick();
    check("R3 right busy low, left first", r_busy_n, 1'b0);
    check("R3 left busy high, left first", l_busy_n, 1'b1);
    tick();
    check("R4 right busy held", r_busy_n, 1'b0);
    drive(1'b1, 10'h2AA, 1'b1, 1'b0, 10'h2AA, 1'b0);
    check("R6 right strobe released after winner leaves", r_we_gated_n, 1'b0);
    tick();
    check("R4 right busy released", r_busy_n, 1'b1);
    idle();
  endtask

  task automatic t_right_first();
    drive(1'b1, 10'h0, 1'b1, 1'b0, 10'h3FF, 1'b1);
    tick();
    drive(1'b0, 10'h3FF, 1'b0, 1'b0, 10'h3FF, 1'b1);
    check("R6 left strobe blocked, right first", l_we_gated_n, 1'b1);
    tick();
    check("R3 left busy low, right first, top addr", l_busy_n, 1'b0);
    check("R3 right busy high, right first", r_busy_n, 1'b1);
    check("R8 busies not both low", l_busy_n | r_busy_n, 1'b1);
    idle();
    check("R4 left busy released on idle", l_busy_n, 1'b1);
  endtask

  task automatic t_tie_and_move();
    drive(1'b0, 10'h0, 1'b0, 1'b0, 10'h0, 1'b0);
    check("R5 tie: right strobe blocked", r_we_gated_n, 1'b1);
    check("R5 tie: left strobe passes", l_we_gated_n, 1'b0);
    tick();
    check("R5 tie: right busy low", r_busy_n, 1'b0);
    check("R5 tie: left busy high", l_busy_n, 1'b1);
    drive(1'b0, 10'h0, 1'b1, 1'b0, 10'h1, 1'b0);
    check("R7 right strobe passes after move", r_we_gated_n, 1'b0);
    tick();
    check("R7 right busy high after address move", r_busy_n, 1'b1);
    idle();
  endtask

  task automatic t_reset_mid();
    drive(1'b0, 10'h0CC, 1'b1, 1'b0, 10'h0CC, 1'b1);
    tick();
    check("R5 collision set before reset", r_busy_n, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 right busy high in reset", r_busy_n, 1'b1);
    check("R1 left busy high in reset", l_busy_n, 1'b1);
    @(negedge clk);
    l_sel_n = 1'b1; r_sel_n = 1'b1;
    rst_n = 1'b1;
    tick();
    check("R1 busy stays high after reset", r_busy_n, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    l_sel_n = 1'b1; r_sel_n = 1'b1; l_we_n = 1'b1; r_we_n = 1'b1;
    l_addr = '0; r_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_no_collision();
    t_left_first();
    t_right_first();
    t_tie_and_move();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule